// File: doc/BRIEF.md
# Calibrated Seconds Counter with Alarm

This core keeps wall-clock time for a real-time-clock subsystem. A slow crystal enable, `xtal_en`, is high for one system clock per crystal period. A tick divider counts these enables. When it reaches the integer part of a programmable calibration word it closes one second. A 4-bit fraction accumulator can add one extra tick to some seconds. This trims the average second to a crystal frequency that is not a whole number of ticks.

A 32-bit seconds counter advances at every second boundary. Each boundary produces a one-cycle `sec_evt` pulse. If the new time equals the alarm register, a one-cycle `alarm_evt` pulse goes out with it. A newly written time value waits for the next boundary before it reaches the counter. Software therefore writes the time it wants to see one second later. A calibration write restarts the divider, so the first boundary after it falls exactly one full period later. Registers are written and read through a simple select/data port.

The divider is a two-state machine:

- `DIV_RUN` counts crystal ticks.
- `DIV_EXTRA` spends the one stretch tick.

Divider transitions:

- RUN→RUN while counting.
- RUN→RUN with a boundary strobe when the limit is reached and no stretch is due.
- RUN→EXTRA when the limit is reached and a stretch is due.
- EXTRA→RUN with the strobe.
- Any state→RUN on a calibration write.

The time tracker is a second two-state machine:

- `TIME_FREE` increments the counter at each boundary.
- `TIME_PENDING` holds a written value that will load at the next boundary.

Time-tracker transitions:

- FREE→PENDING on a time write.
- PENDING→FREE at a boundary, which loads the value.
- PENDING→PENDING when a new write lands in the same cycle as the boundary.

Top module: `rtc_core`

## Requirements
- R1: After reset the calibration register reads 0x198233. Set-time, alarm, current time and tick count all read 0, and neither event output is high.
- R2: The tick counter advances only in cycles with `xtal_en` high. With fraction correction off, a second lasts (calibration bits 15:0) + 1 crystal ticks.
- R3: A calibration write keeps only write-data bits 20:0 and clears the tick counter. The next boundary comes exactly one full second period after the write.
- R4: With calibration bit 20 set, each boundary adds the fraction field (bits 19:16) to a 4-bit accumulator. A carry out of that add makes the following second one tick longer. A calibration write clears the accumulator.
- R5: A set-time write reads back at once on select 0. It reaches `cur_time` only at the next boundary, not before.
- R6: Without a pending load, `cur_time` increases by one at each boundary, wraps from 0xFFFFFFFF to 0, and holds between boundaries.
- R7: `sec_evt` is high for exactly one cycle per boundary, the cycle in which `cur_time` first shows the new value.
- R8: `alarm_evt` pulses together with `sec_evt` when the new time equals the alarm register, and is never high otherwise.
- R9: The read port returns data by select code: 0 set-time, 1 calibration (zero-extended from 21 bits), 2 alarm, 3 current time, 4 tick count (zero-extended from 16 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_en | input | 1 | One-cycle crystal tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 set-time, 1 calibration, 2 alarm |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read select (see R9) |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| cur_time | output | 32 | Current seconds count |
| sec_evt | output | 1 | One-cycle pulse per second boundary |
| alarm_evt | output | 1 | One-cycle pulse on alarm match |

## Verification
The bench restarts the divider with small calibration values and measures the exact number of cycles between boundaries. An off-by-one limit compare, a calibration write that does not clear the counter, or a stretch applied one second late each shows up as a wrong gap. A fractional run checks the stretch pattern 10, 10, 11, 10, 11, so an accumulator that ignores its carry or stretches the wrong second fails. Set-time is checked for being invisible before the boundary and visible at it, since a design that loads at once would expose the value a second early. A run across the 0xFFFFFFFF wrap with the alarm at 0 shows whether the counter rolls over and whether the compare uses the new time rather than the old one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int TIME_W = 32;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 4;
    localparam int CAL_W  = INT_W + FRAC_W + 1;
    localparam int SEL_W  = 3;
    localparam logic [CAL_W-1:0] CAL_RESET = 21'h198233;

    typedef enum logic [SEL_W-1:0] {
        RSEL_SET   = 3'd0,
        RSEL_CAL   = 3'd1,
        RSEL_ALARM = 3'd2,
        RSEL_TIME  = 3'd3,
        RSEL_TICK  = 3'd4
    } rsel_e;

    typedef enum logic {
        DIV_RUN   = 1'b0,
        DIV_EXTRA = 1'b1
    } div_state_e;

    typedef enum logic {
        TIME_FREE    = 1'b0,
        TIME_PENDING = 1'b1
    } time_state_e;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_en,
    input  logic             cal_wr,
    input  logic [CAL_W-1:0] cal,
    output logic             strobe,
    output logic [INT_W-1:0] tick_cnt
);
    logic [INT_W-1:0]  lim;
    logic [FRAC_W-1:0] frac;
    logic              frac_en;
    assign lim     = cal[INT_W-1:0];
    assign frac    = cal[INT_W+FRAC_W-1:INT_W];
    assign frac_en = cal[CAL_W-1];

    div_state_e        st, st_n;
    logic [INT_W-1:0]  cnt, cnt_n;
    logic [FRAC_W-1:0] acc, acc_n;
    logic              stretch, stretch_n;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, frac};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= DIV_RUN;
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            acc     <= acc_n;
            stretch <= stretch_n;
        end
    end

    // Next state and boundary strobe
    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        acc_n     = acc;
        stretch_n = stretch;
        strobe    = 1'b0;
        if (cal_wr) begin
            st_n      = DIV_RUN;
            cnt_n     = '0;
            acc_n     = '0;
            stretch_n = 1'b0;
        end else if (xtal_en) begin
            unique case (st)
                DIV_RUN: begin
                    if (cnt == lim) begin
                        if (stretch) begin
                            st_n = DIV_EXTRA;
                        end else begin
                            strobe    = 1'b1;
                            cnt_n     = '0;
                            acc_n     = frac_en ? sum[FRAC_W-1:0] : acc;
                            stretch_n = frac_en & sum[FRAC_W];
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                DIV_EXTRA: begin
                    strobe    = 1'b1;
                    st_n      = DIV_RUN;
                    cnt_n     = '0;
                    acc_n     = frac_en ? sum[FRAC_W-1:0] : acc;
                    stretch_n = frac_en & sum[FRAC_W];
                end
            endcase
        end
    end

    assign tick_cnt = cnt;

    assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xtal_en && !cal_wr) |=> $stable(tick_cnt));
    assert_tick_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= lim);
    assert_cal_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr |=> (tick_cnt == '0));
endmodule

// File: rtl/rtc_sec_track.sv
module rtc_sec_track
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              set_wr,
    input  logic [TIME_W-1:0] set_val,
    input  logic [TIME_W-1:0] alarm_val,
    output logic [TIME_W-1:0] cur_time,
    output logic              sec_evt,
    output logic              alarm_evt
);
    time_state_e       st, st_n;
    logic [TIME_W-1:0] cur, nxt;

    always_comb begin
        nxt  = (st == TIME_PENDING) ? set_val : cur + 1'b1;
        st_n = st;
        unique case (st)
            TIME_FREE:    if (set_wr) st_n = TIME_PENDING;
            TIME_PENDING: if (strobe && !set_wr) st_n = TIME_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= TIME_FREE;
        end else begin
            st <= st_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            sec_evt   <= 1'b0;
            alarm_evt <= 1'b0;
        end else begin
            sec_evt   <= strobe;
            alarm_evt <= strobe && (nxt == alarm_val);
            if (strobe) cur <= nxt;
        end
    end

    assign cur_time = cur;

    assert_time_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(cur_time));
    assert_load_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && st == TIME_PENDING) |=> (cur_time == $past(set_val)));
    assert_alarm_with_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> sec_evt);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [TIME_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [TIME_W-1:0] rd_data,
    output logic [TIME_W-1:0] cur_time,
    output logic              sec_evt,
    output logic              alarm_evt
);
    logic [CAL_W-1:0]  cal_q;
    logic [TIME_W-1:0] set_q, alarm_q;
    logic [INT_W-1:0]  tick;
    logic              strobe, cal_wr, set_wr, alarm_wr;

    assign cal_wr   = wr_en && (rsel_e'(wr_sel) == RSEL_CAL);
    assign set_wr   = wr_en && (rsel_e'(wr_sel) == RSEL_SET);
    assign alarm_wr = wr_en && (rsel_e'(wr_sel) == RSEL_ALARM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q   <= CAL_RESET;
            set_q   <= '0;
            alarm_q <= '0;
        end else begin
            if (cal_wr)   cal_q   <= wr_data[CAL_W-1:0];
            if (set_wr)   set_q   <= wr_data;
            if (alarm_wr) alarm_q <= wr_data;
        end
    end

    rtc_tick_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .xtal_en  (xtal_en),
        .cal_wr   (cal_wr),
        .cal      (cal_q),
        .strobe   (strobe),
        .tick_cnt (tick)
    );

    rtc_sec_track u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .set_wr    (set_wr),
        .set_val   (set_q),
        .alarm_val (alarm_q),
        .cur_time  (cur_time),
        .sec_evt   (sec_evt),
        .alarm_evt (alarm_evt)
    );

    always_comb begin
        case (rsel_e'(rd_sel))
            RSEL_SET:   rd_data = set_q;
            RSEL_CAL:   rd_data = {{(TIME_W-CAL_W){1'b0}}, cal_q};
            RSEL_ALARM: rd_data = alarm_q;
            RSEL_TIME:  rd_data = cur_time;
            RSEL_TICK:  rd_data = {{(TIME_W-INT_W){1'b0}}, tick};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data, cur_time;
    logic        sec_evt, alarm_evt;

    always #2.5 clk = ~clk;

    rtc_core i_rtc_core (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cur_time(cur_time), .sec_evt(sec_evt), .alarm_evt(alarm_evt)
    );

    typedef struct {
        int          gap;
        logic [31:0] t;
        bit          al;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    last_mark = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected boundaries as the design produces them
    always @(negedge clk) begin
        if (rst_n && sec_evt) begin
            int gap;
            gap = cyc - last_mark;
            last_mark = cyc;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(gap == it.gap, it.tag, "second period", gap, it.gap);
                chk(cur_time == it.t, "R7", "time at sec_evt", cur_time, it.t);
                chk(alarm_evt == it.al, "R8", "alarm_evt", {31'b0, alarm_evt}, {31'b0, it.al});
            end
        end else if (rst_n && alarm_evt) begin
            chk(1'b0, "R8", "alarm without sec_evt", 1, 0);
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] sel, input logic [31:0] exp,
                            input string req, input string what);
        rd_sel = sel;
        #1;
        chk(rd_data == exp, req, what, rd_data, exp);
    endtask

    task automatic push(input int gap, input logic [31:0] t, input bit al, input string tag);
        item_t it;
        it.gap = gap; it.t = t; it.al = al; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic start_run(input logic [31:0] cal, input logic [31:0] t);
        wr(3'd1, cal);
        last_mark = cyc;
        wr(3'd0, t);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_check(3'd1, 32'h0019_8233, "R1", "reset calibration");
        rd_check(3'd0, 32'h0, "R1", "reset set-time");
        rd_check(3'd2, 32'h0, "R1", "reset alarm");
        chk(cur_time == 0, "R1", "reset time", cur_time, 0);
        chk(!sec_evt && !alarm_evt, "R1", "reset events", {30'b0, sec_evt, alarm_evt}, 0);

        // Run A: integer only, bits above 20 dropped, alarm at 102
        wr(3'd2, 32'd102);
        start_run(32'hFFE0_0009, 32'd100);
        rd_check(3'd1, 32'h0000_0009, "R3", "calibration masked to 21 bits");
        rd_check(3'd0, 32'd100, "R5", "set-time readback");
        chk(cur_time == 0, "R5", "set-time not yet applied", cur_time, 0);
        push(10, 32'd100, 1'b0, "R3");
        push(10, 32'd101, 1'b0, "R2");
        push(10, 32'd102, 1'b1, "R2");
        drain();

        // Run B: fractional stretch, fraction 8, enabled
        start_run(32'h0018_0009, 32'd500);
        push(10, 32'd500, 1'b0, "R4");
        push(10, 32'd501, 1'b0, "R4");
        push(11, 32'd502, 1'b0, "R4");
        push(10, 32'd503, 1'b0, "R4");
        push(11, 32'd504, 1'b0, "R4");
        drain();

        // Run C: wrap with alarm at 0
        wr(3'd2, 32'd0);
        start_run(32'h0000_0004, 32'hFFFF_FFFE);
        push(5, 32'hFFFF_FFFE, 1'b0, "R2");
        push(5, 32'hFFFF_FFFF, 1'b0, "R6");
        push(5, 32'h0000_0000, 1'b1, "R6");
        push(5, 32'h0000_0001, 1'b0, "R6");
        drain();

        // Run D: set-time mid-second, deferred to the boundary
        t0 = cur_time;
        wr(3'd0, 32'd7);
        chk(cur_time == t0, "R5", "time unchanged before boundary", cur_time, t0);
        rd_check(3'd0, 32'd7, "R5", "set-time readback mid-second");
        push(5, 32'd7, 1'b0, "R5");
        push(5, 32'd8, 1'b0, "R6");
        drain();

        // Run E: tick gating and read port
        xtal_en = 1'b0;
        wr(3'd1, 32'h0000_0064);
        repeat (4) @(negedge clk);
        rd_check(3'd4, 32'd0, "R2", "tick holds without crystal enable");
        xtal_en = 1'b1;
        repeat (6) @(negedge clk);
        xtal_en = 1'b0;
        rd_check(3'd4, 32'd6, "R9", "tick readback");
        rd_check(3'd1, 32'h0000_0064, "R9", "calibration readback");
        rd_check(3'd2, 32'd0, "R9", "alarm readback");
        rd_check(3'd3, cur_time, "R9", "time readback matches output");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule